// File: doc/BRIEF.md
# Change-of-State Interrupt Controller

This block watches thirty-two external lines: twenty-four isolated inputs and eight TTL lines. It reports when any of them changes level, raising a single interrupt for software. The lines are grouped in fours-of-eight: three isolated groups and one TTL group. Each group has an independent enable for rising edges and another for falling edges. When a line shows an edge of an enabled polarity, a status flag for that line is latched and held until software clears it.

Software reaches the block through a small synchronous byte-wide register port. Read data is combinational from the address. Writing a byte to a status offset clears exactly the flags that are one in the written byte, so writing back a value just read acknowledges only those events. Every raw line is resynchronised before edge detection, so the inputs may be fully asynchronous to the block clock.

Top module: `cos_irq_ctrl`

## Requirements
- R1: After reset, the enable register reads 0x00, all four status bytes read 0x00 and `irq` is low.
- R2: Offset 0xE holds the 8-bit enable register. A write there stores the byte, and a read returns it unchanged. The register changes only on a write to 0xE.
- R3: Enable bits 0, 1, 2 and 3 enable rising-edge (0 to 1) detection for lines 0-7, 8-15, 16-23 and the TTL lines 0-7, respectively.
- R4: Enable bits 4, 5, 6 and 7 enable falling-edge (1 to 0) detection for those same four groups, in the same order.
- R5: Reading offsets 0x8, 0x9 and 0xA returns the status of isolated lines 0-7, 8-15 and 16-23, with line 8k+j at bit j of offset 0x8+k. Reading offset 0xB returns the TTL status, with TTL line j at bit j.
- R6: A write to a status offset (0x8-0xB) clears the status bits of that byte that are one in the written data. Every other status bit keeps its value.
- R7: `irq` is high in every cycle where at least one status bit is set. It returns low once every status bit has been cleared.
- R8: If a qualifying edge and a clear write reach the same status bit in the same cycle, the bit stays set.
- R9: Clearing an enable bit leaves status bits that are already latched untouched. Edges of the disabled polarity in that group then set nothing.
- R10: Each line passes through a two-stage synchroniser followed by a one-cycle edge comparison. A level change is visible in status at the third rising clock edge after the change, and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| bus_addr | input | 4 | Byte offset for read and write |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr; 0 at unused offsets |
| iso_in | input | 24 | Raw isolated input lines, asynchronous |
| ttl_in | input | 8 | Raw TTL lines, asynchronous |
| irq | output | 1 | Level interrupt, high while any status bit is set |

## Verification
The bench targets the cases where a plausible design goes quietly wrong. It checks that a partial write-back clears only the named bits; a design that cleared the whole byte would lose pending events. It drives a new edge into the very cycle a clear lands on the same bit; a design that let the clear win would drop that event. It also confirms that turning an enable off leaves latched flags alone; a design that masked status with the enables would lose flags. Finally, it times a level change against the clock to show status appears exactly at the third edge, which exposes a synchroniser that is too shallow or too deep. A walked table with mixed enable bytes and input patterns shows that each enable bit reaches the right group and polarity, and that each group reads back from its own offset.

// File: rtl/cos_pkg.sv
package cos_pkg;

   // Per-group edge qualification derived from the packed enable byte.
   typedef struct packed {
      logic rise;
      logic fall;
   } edge_en_t;

   localparam int unsigned COS_MIN_SYNC = 2;

endpackage

// File: rtl/cos_sync.sv
module cos_sync #(
   parameter int unsigned W      = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   import cos_pkg::*;

   generate
      if (STAGES < COS_MIN_SYNC) begin : g_bad_depth
         $error("cos_sync: STAGES must be at least %0d", COS_MIN_SYNC);
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else begin
         chain_q[0] <= d;
         for (int s = 1; s < STAGES; s++) begin
            chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/cos_group.sv
module cos_group #(
   parameter int unsigned W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [W-1:0]       lvl,
   input  cos_pkg::edge_en_t  en,
   input  logic               clr_stb,
   input  logic [W-1:0]       clr_mask,
   output logic [W-1:0]       stat
);
   logic [W-1:0] prev_q;
   logic [W-1:0] stat_q;
   logic [W-1:0] rise_hit;
   logic [W-1:0] fall_hit;
   logic [W-1:0] hit;
   logic [W-1:0] clr_v;

   always_comb begin
      rise_hit = lvl & ~prev_q & {W{en.rise}};
      fall_hit = ~lvl & prev_q & {W{en.fall}};
      hit      = rise_hit | fall_hit;
      clr_v    = clr_stb ? clr_mask : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= '0;
         stat_q <= '0;
      end else begin
         prev_q <= lvl;
         // New events take priority over a coincident clear.
         stat_q <= (stat_q & ~clr_v) | hit;
      end
   end

   assign stat = stat_q;

   // A flag may only rise when a qualifying edge was seen the cycle before.
   p_set_needs_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(hit)) == '0));

   // Cleared bits without a coincident edge must read zero afterwards.
   p_clear_takes_r6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((stat_q & $past(clr_v & ~hit)) == '0));

   // Bits left out of the clear mask keep their value unless an edge sets them.
   p_clear_spares_r6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(stat_q) & ~$past(clr_v)) & ~stat_q) == '0));

   // An edge in the same cycle as a clear leaves the bit set.
   p_edge_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((stat_q & $past(hit)) == $past(hit)));

endmodule

// File: rtl/cos_irq_ctrl.sv
module cos_irq_ctrl #(
   parameter int unsigned GROUPS      = 4,
   parameter int unsigned GRP_W       = 8,
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned STAT_BASE   = 8,
   parameter int unsigned ENA_ADDR    = 14,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned ISO_W      = (GROUPS - 1) * GRP_W,
   localparam int unsigned LINES      = GROUPS * GRP_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [GRP_W-1:0]  bus_wdata,
   output logic [GRP_W-1:0]  bus_rdata,
   input  logic [ISO_W-1:0]  iso_in,
   input  logic [GRP_W-1:0]  ttl_in,
   output logic              irq
);
   import cos_pkg::*;

   generate
      if (2 * GROUPS != GRP_W) begin : g_bad_ena
         $error("cos_irq_ctrl: enable byte needs 2*GROUPS == GRP_W");
      end
      if (GROUPS < 2) begin : g_bad_groups
         $error("cos_irq_ctrl: at least one isolated and one TTL group");
      end
      if (ENA_ADDR >= STAT_BASE && ENA_ADDR < STAT_BASE + GROUPS) begin : g_bad_map
         $error("cos_irq_ctrl: enable offset overlaps status offsets");
      end
      if (STAT_BASE + GROUPS > (1 << ADDR_W) || ENA_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
         $error("cos_irq_ctrl: offsets do not fit ADDR_W");
      end
   endgenerate

   logic [LINES-1:0]             raw_lines;
   logic [LINES-1:0]             sync_lines;
   logic [GRP_W-1:0]             ena_q;
   logic                         ena_wr;
   logic [GROUPS-1:0]            clr_stb;
   logic [GROUPS-1:0][GRP_W-1:0] stat_bytes;
   logic [GROUPS-1:0]            grp_pending;

   assign raw_lines = {ttl_in, iso_in};

   cos_sync #(
      .W      (LINES),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_lines),
      .q     (sync_lines)
   );

   assign ena_wr = bus_wr && (bus_addr == ADDR_W'(ENA_ADDR));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ena_q <= '0;
      end else if (ena_wr) begin
         ena_q <= bus_wdata;
      end
   end

   genvar g;
   generate
      for (g = 0; g < GROUPS; g++) begin : g_grp
         edge_en_t grp_en;
         assign grp_en.rise = ena_q[g];
         assign grp_en.fall = ena_q[g + GROUPS];
         assign clr_stb[g]  = bus_wr && (bus_addr == ADDR_W'(STAT_BASE + g));

         cos_group #(
            .W (GRP_W)
         ) u_grp (
            .clk      (clk),
            .rst_n    (rst_n),
            .lvl      (sync_lines[g*GRP_W +: GRP_W]),
            .en       (grp_en),
            .clr_stb  (clr_stb[g]),
            .clr_mask (bus_wdata),
            .stat     (stat_bytes[g])
         );

         assign grp_pending[g] = |stat_bytes[g];
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(ENA_ADDR)) begin
         bus_rdata = ena_q;
      end
      for (int k = 0; k < GROUPS; k++) begin
         if (bus_addr == ADDR_W'(STAT_BASE + k)) begin
            bus_rdata = stat_bytes[k];
         end
      end
   end

   assign irq = |grp_pending;

   // The enable byte moves only on a write to its own offset.
   p_ena_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(ena_wr) |-> $stable(ena_q));

   // The interrupt can only drop after software wrote a clear.
   p_irq_drop_needs_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> $past(bus_wr));

   // Writing zero to the enable byte must not disturb pending status.
   p_disable_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ena_wr) && !$past(|clr_stb)) |-> ($countones(stat_bytes) >= $countones($past(stat_bytes))));

endmodule

// File: tb/cos_irq_ctrl_test.sv
`timescale 1ns/1ps
module cos_irq_ctrl_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [23:0] iso_in = '0;
   logic [7:0]  ttl_in = '0;
   logic        irq;

   int n_run  = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   cos_irq_ctrl uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .iso_in    (iso_in),
      .ttl_in    (ttl_in),
      .irq       (irq)
   );

   // {enable byte, isolated lines, TTL lines}
   localparam logic [39:0] VEC [8] = '{
      {8'h01, 24'h0000A5, 8'h00},
      {8'h10, 24'h00005A, 8'h00},
      {8'h02, 24'h00FF5A, 8'h0F},
      {8'h08, 24'h00FF5A, 8'hF0},
      {8'h80, 24'h00FF5A, 8'h00},
      {8'hFF, 24'hC300A5, 8'h3C},
      {8'h00, 24'h000000, 8'hFF},
      {8'h44, 24'hFF0000, 8'h00}
   };

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      bus_addr = a;
      #0.5;
      d = bus_rdata;
   endtask

   task automatic clear_all();
      for (int k = 0; k < 4; k++) wr(4'(8 + k), 8'hFF);
   endtask

   initial begin
      #(5.0 * 150000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [7:0]  rv;
      logic [31:0] prev_l, new_l, exp_s, got_s;
      logic [7:0]  ena;

      tick(3);
      // R1: reset state
      for (int k = 8; k < 12; k++) begin
         rd(4'(k), rv);
         check("R1 status", {24'h0, rv}, 32'h0);
      end
      rd(4'hE, rv);
      check("R1 enable", {24'h0, rv}, 32'h0);
      check("R1 irq", {31'h0, irq}, 32'h0);
      rst_n = 1'b1;
      tick(2);

      // R2: enable readback
      wr(4'hE, 8'h5C);
      rd(4'hE, rv);
      check("R2 enable readback", {24'h0, rv}, 32'h5C);
      wr(4'h8, 8'h00);
      rd(4'hE, rv);
      check("R2 enable held on other write", {24'h0, rv}, 32'h5C);

      // R3 R4 R5 R7: walked table, expected from an edge model
      for (int v = 0; v < 8; v++) begin
         ena = VEC[v][39:32];
         wr(4'hE, 8'h00);
         clear_all();
         wr(4'hE, ena);
         prev_l = {ttl_in, iso_in};
         new_l  = {VEC[v][7:0], VEC[v][31:8]};
         iso_in = VEC[v][31:8];
         ttl_in = VEC[v][7:0];
         tick(5);
         exp_s = '0;
         for (int g = 0; g < 4; g++) begin
            exp_s[g*8 +: 8] = ((new_l[g*8 +: 8] & ~prev_l[g*8 +: 8]) & {8{ena[g]}})
                            | ((~new_l[g*8 +: 8] & prev_l[g*8 +: 8]) & {8{ena[g+4]}});
         end
         for (int g = 0; g < 4; g++) begin
            rd(4'(8 + g), rv);
            got_s[g*8 +: 8] = rv;
         end
         check("R3/R4/R5 table status", got_s, exp_s);
         check("R7 table irq", {31'h0, irq}, {31'h0, exp_s != 0});
      end

      // R10: latency of exactly three edges (inputs now iso=FF0000, ttl=00)
      wr(4'hE, 8'h01);
      clear_all();
      iso_in[0] = 1'b1;
      @(posedge clk); @(posedge clk); @(negedge clk);
      rd(4'h8, rv);
      check("R10 not before third edge", {24'h0, rv}, 32'h00);
      @(posedge clk); @(negedge clk);
      rd(4'h8, rv);
      check("R10 at third edge", {24'h0, rv}, 32'h01);

      // R6: partial clear
      iso_in[2:1] = 2'b11;
      tick(5);
      rd(4'h8, rv);
      check("R6 setup", {24'h0, rv}, 32'h07);
      wr(4'h8, 8'h02);
      rd(4'h8, rv);
      check("R6 partial clear", {24'h0, rv}, 32'h05);
      check("R7 irq still set", {31'h0, irq}, 32'h1);
      wr(4'h8, 8'h05);
      rd(4'h8, rv);
      check("R6 full clear", {24'h0, rv}, 32'h00);
      check("R7 irq low after clear", {31'h0, irq}, 32'h0);

      // R9: disabling keeps latched flags, new edges ignored
      iso_in[3] = 1'b1;
      tick(5);
      wr(4'hE, 8'h00);
      rd(4'h8, rv);
      check("R9 flag kept after disable", {24'h0, rv}, 32'h08);
      iso_in[4] = 1'b1;
      tick(5);
      rd(4'h8, rv);
      check("R9 disabled edge ignored", {24'h0, rv}, 32'h08);
      check("R9 irq still high", {31'h0, irq}, 32'h1);

      // R8: edge and clear in the same cycle
      wr(4'hE, 8'h11);
      clear_all();
      iso_in[5] = 1'b1;
      tick(5);
      rd(4'h8, rv);
      check("R8 setup", {24'h0, rv}, 32'h20);
      iso_in[5] = 1'b0;
      @(posedge clk); @(posedge clk); @(negedge clk);
      bus_addr  = 4'h8;
      bus_wdata = 8'h20;
      bus_wr    = 1'b1;
      @(posedge clk); @(negedge clk);
      bus_wr    = 1'b0;
      rd(4'h8, rv);
      check("R8 edge beats clear", {24'h0, rv}, 32'h20);
      wr(4'h8, 8'h20);
      rd(4'h8, rv);
      check("R8 later clear works", {24'h0, rv}, 32'h00);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule